// File: doc/BRIEF.md
# Host and Firmware Message Mailbox

This block is a small register-mapped mailbox through which host software and an embedded controller exchange one 32-bit message at a time. A message word packs an 8-bit command type above a 24-bit payload. Either side must hold the mailbox before it writes a message, and a three-state owner register arbitrates this. The host reaches the block through a simple register bus with read and write strobes, an address, write data and registered read data. The firmware side has dedicated strobes to claim and release the mailbox, to take delivery of the inbound word, to post an outbound word and to flag a hang.

The host delivers a word to the firmware by writing the inbound data register and then setting the master and firmware enable bits in the command register. This raises the firmware interrupt. The firmware answers by posting an outbound word. If the host has set the status-interrupt enable bit in the command register, that post latches an event flag and raises the host interrupt. The host clears the flags by writing ones to them. To reply, the host writes an ACK word (type 128) or a NAK word (type 129) and sets the delivery bits again. To finish, it clears the status-interrupt enable bit and writes the free code to the owner register. Requests use command types 1 to 15. The block gives no meaning to any type.

Top module: `hostfw_mailbox`

## Requirements
- R1: After reset the owner register reads 0, the command, inbound, outbound and status registers read 0, and both interrupt outputs are low.
- R2: The owner register at offset 0xF0 uses 0 for free, 1 for firmware-owned and 2 for host-owned, and never holds 3. A host write of 2 takes effect only while the mailbox is free. Host writes of any other nonzero value are ignored, and the firmware can neither take nor release a host-owned mailbox.
- R3: A firmware claim sets the owner to 1 only while the mailbox is free. When a host claim and a firmware claim arrive in the same cycle on a free mailbox, the firmware wins.
- R4: A host write of 0 to the owner register frees the mailbox from any state. A firmware release frees it only while the owner is 1.
- R5: The inbound word at offset 0xE8 is host-writable only while the owner is not 0. The firmware sees its bits 31:24 as the type and its bits 23:0 as the payload.
- R6: A firmware post is accepted only while the owner is 1. It stores the word {type in bits 31:24, payload in bits 23:0}, which the host reads at offset 0xEC. A post that is not accepted leaves that word unchanged.
- R7: The command register at offset 0xE4 implements bits 31:27 (31 master, 30 controller enable, 29 status-interrupt enable, 28 power-event enable, 27 firmware enable). Other bits read 0. Host writes to it are accepted only while the owner is not 0. The firmware interrupt equals bit 31 AND bit 27. A firmware take clears bit 27, but a host write in the same cycle takes precedence.
- R8: The status register at offset 0x428 holds bit 1 (hang, set by the firmware hang strobe) and bit 3 (event, set by an accepted post while command bit 29 is 1). Its other bits read 0. Writing a 1 to a bit clears it, and a set in the same cycle wins over the clear.
- R9: The host interrupt is high exactly while command bit 29 is 1 and status bit 1 or bit 3 is 1. It stays high until the flags are cleared or bit 29 is cleared.
- R10: Read data appears on the cycle after the read strobe and holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | ADDR_W (12) | Host register byte offset |
| h_wdata | input | DATA_W (32) | Host write data |
| h_rdata | output | DATA_W (32) | Registered host read data |
| h_irq | output | 1 | Interrupt toward the host |
| f_claim | input | 1 | Firmware claims the mailbox |
| f_release | input | 1 | Firmware releases the mailbox |
| f_take | input | 1 | Firmware takes delivery (clears firmware enable) |
| f_hang | input | 1 | Firmware raises the hang flag |
| f_post | input | 1 | Firmware posts an outbound word |
| f_out_type | input | TYPE_W (8) | Type of the posted word |
| f_out_data | input | DATA_W-TYPE_W (24) | Payload of the posted word |
| f_irq | output | 1 | Interrupt toward the firmware |
| f_owner | output | 2 | Current owner code |
| f_in_type | output | TYPE_W (8) | Type field of the inbound word |
| f_in_data | output | DATA_W-TYPE_W (24) | Payload field of the inbound word |

## Verification
The bench exercises two pairs of events that can fall in the same cycle. In the first pair, the host writes the host code to a free owner register while the firmware asserts its claim in that same cycle. The result is judged by the owner code on the firmware port and by a host read-back, both of which must show firmware ownership. In the second pair, the host writes a one to clear the event flag while an accepted firmware post sets it in the same cycle. The status read-back must still show the flag. A behavioural reference model compares every output on every cycle, so any cycle in which the two sides disagree is reported.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum logic [1:0] {
      OWN_FREE = 2'd0,
      OWN_FW   = 2'd1,
      OWN_HOST = 2'd2
   } owner_e;

   // command register bit positions (neighbour firmware decodes them)
   localparam int CMD_FW_EN_BIT   = 27;
   localparam int CMD_PWR_EN_BIT  = 28;
   localparam int CMD_STAT_EN_BIT = 29;
   localparam int CMD_CTL_EN_BIT  = 30;
   localparam int CMD_MASTER_BIT  = 31;

   // status flag positions
   localparam int ST_HANG_BIT  = 1;
   localparam int ST_EVENT_BIT = 3;

endpackage

// File: rtl/mbox_owner_arb.sv
module mbox_owner_arb
   import mbox_pkg::*;
#(
   parameter bit FW_WINS_TIE = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   h_claim,
   input  logic   h_free,
   input  logic   f_claim,
   input  logic   f_release,
   output owner_e owner_q
);

   owner_e owner_d;
   logic   fw_grab;
   logic   host_grab;
   logic   fw_drop;

   always_comb begin
      fw_grab   = f_claim && (owner_q == OWN_FREE);
      host_grab = h_claim && (owner_q == OWN_FREE);
      fw_drop   = f_release && (owner_q == OWN_FW);
   end

   generate
      if (FW_WINS_TIE) begin : g_fw_first
         always_comb begin
            owner_d = owner_q;
            if (fw_grab)        owner_d = OWN_FW;
            else if (host_grab) owner_d = OWN_HOST;
            else if (h_free)    owner_d = OWN_FREE;
            else if (fw_drop)   owner_d = OWN_FREE;
         end
      end else begin : g_host_first
         always_comb begin
            owner_d = owner_q;
            if (host_grab)      owner_d = OWN_HOST;
            else if (fw_grab)   owner_d = OWN_FW;
            else if (h_free)    owner_d = OWN_FREE;
            else if (fw_drop)   owner_d = OWN_FREE;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_FREE;
      else        owner_q <= owner_d;
   end

endmodule

// File: rtl/mbox_cmd_reg.sv
module mbox_cmd_reg
   import mbox_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LO_BIT = CMD_FW_EN_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fw_take,
   output logic [DATA_W-1:0] cmd_q
);

   localparam logic [DATA_W-1:0] IMPL_MASK = {DATA_W{1'b1}} << LO_BIT;

   generate
      if (LO_BIT < 0 || LO_BIT > CMD_FW_EN_BIT) begin : g_bad_lo
         $error("mbox_cmd_reg: LO_BIT must cover the firmware enable bit");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr_en) begin
         cmd_q <= wdata & IMPL_MASK;
      end else if (fw_take) begin
         cmd_q[CMD_FW_EN_BIT] <= 1'b0;
      end
   end

endmodule

// File: rtl/mbox_status_w1c.sv
module mbox_status_w1c #(
   parameter int                 DATA_W    = 32,
   parameter logic [DATA_W-1:0]  FLAG_MASK = 32'h0000_000A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_vec,
   input  logic [DATA_W-1:0] clr_vec,
   output logic [DATA_W-1:0] st_q
);

   generate
      if (FLAG_MASK == '0) begin : g_bad_mask
         $error("mbox_status_w1c: FLAG_MASK selects no flag");
      end
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         if (FLAG_MASK[i]) begin : g_flop
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) bit_q <= 1'b0;
               else        bit_q <= set_vec[i] | (bit_q & ~clr_vec[i]);
            end
            assign st_q[i] = bit_q;
         end else begin : g_tie
            assign st_q[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/hostfw_mailbox.sv
module hostfw_mailbox
   import mbox_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int TYPE_W      = 8,
   parameter int OFS_CMD     = 'hE4,
   parameter int OFS_IN      = 'hE8,
   parameter int OFS_OUT     = 'hEC,
   parameter int OFS_OWN     = 'hF0,
   parameter int OFS_STAT    = 'h428,
   parameter bit FW_WINS_TIE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     h_wr,
   input  logic                     h_rd,
   input  logic [ADDR_W-1:0]        h_addr,
   input  logic [DATA_W-1:0]        h_wdata,
   output logic [DATA_W-1:0]        h_rdata,
   output logic                     h_irq,
   input  logic                     f_claim,
   input  logic                     f_release,
   input  logic                     f_take,
   input  logic                     f_hang,
   input  logic                     f_post,
   input  logic [TYPE_W-1:0]        f_out_type,
   input  logic [DATA_W-TYPE_W-1:0] f_out_data,
   output logic                     f_irq,
   output logic [1:0]               f_owner,
   output logic [TYPE_W-1:0]        f_in_type,
   output logic [DATA_W-TYPE_W-1:0] f_in_data
);

   localparam int PAY_W = DATA_W - TYPE_W;
   localparam logic [DATA_W-1:0] STAT_MASK =
      (DATA_W'(1) << ST_HANG_BIT) | (DATA_W'(1) << ST_EVENT_BIT);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
   localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
   localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
   localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("hostfw_mailbox: command bit layout needs a 32-bit word");
      end
      if (TYPE_W < 1 || TYPE_W >= DATA_W) begin : g_bad_type
         $error("hostfw_mailbox: TYPE_W out of range");
      end
      if (OFS_STAT >= (1 << ADDR_W) || OFS_OWN >= (1 << ADDR_W)) begin : g_bad_addr
         $error("hostfw_mailbox: ADDR_W too narrow for the register offsets");
      end
   endgenerate

   // address decode
   logic sel_cmd, sel_in, sel_out, sel_own, sel_stat;
   always_comb begin
      sel_cmd  = (h_addr == A_CMD);
      sel_in   = (h_addr == A_IN);
      sel_out  = (h_addr == A_OUT);
      sel_own  = (h_addr == A_OWN);
      sel_stat = (h_addr == A_STAT);
   end

   // ownership
   owner_e owner_q;
   logic   owned;
   logic   host_claim;
   logic   host_free;

   always_comb begin
      host_claim = h_wr && sel_own && (h_wdata == DATA_W'(OWN_HOST));
      host_free  = h_wr && sel_own && (h_wdata == DATA_W'(OWN_FREE));
   end

   mbox_owner_arb #(
      .FW_WINS_TIE (FW_WINS_TIE)
   ) u_owner (
      .clk       (clk),
      .rst_n     (rst_n),
      .h_claim   (host_claim),
      .h_free    (host_free),
      .f_claim   (f_claim),
      .f_release (f_release),
      .owner_q   (owner_q)
   );

   assign owned   = (owner_q != OWN_FREE);
   assign f_owner = owner_q;

   // command register
   logic [DATA_W-1:0] cmd_q;

   mbox_cmd_reg #(
      .DATA_W (DATA_W),
      .LO_BIT (CMD_FW_EN_BIT)
   ) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (h_wr && sel_cmd && owned),
      .wdata   (h_wdata),
      .fw_take (f_take),
      .cmd_q   (cmd_q)
   );

   // message words
   logic [DATA_W-1:0] in_q;
   logic [DATA_W-1:0] out_q;
   logic              post_ok;

   assign post_ok = f_post && (owner_q == OWN_FW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         out_q <= '0;
      end else begin
         if (h_wr && sel_in && owned) in_q  <= h_wdata;
         if (post_ok)                 out_q <= {f_out_type, f_out_data};
      end
   end

   assign f_in_type = in_q[DATA_W-1:PAY_W];
   assign f_in_data = in_q[PAY_W-1:0];

   // status flags, write one to clear
   logic [DATA_W-1:0] stat_set;
   logic [DATA_W-1:0] stat_clr;
   logic [DATA_W-1:0] stat_q;

   always_comb begin
      stat_set               = '0;
      stat_set[ST_HANG_BIT]  = f_hang;
      stat_set[ST_EVENT_BIT] = post_ok && cmd_q[CMD_STAT_EN_BIT];
      stat_clr               = (h_wr && sel_stat) ? h_wdata : '0;
   end

   mbox_status_w1c #(
      .DATA_W    (DATA_W),
      .FLAG_MASK (STAT_MASK)
   ) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (stat_set),
      .clr_vec (stat_clr),
      .st_q    (stat_q)
   );

   // registered read path
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      rd_mux = '0;
      if (sel_cmd)       rd_mux = cmd_q;
      else if (sel_in)   rd_mux = in_q;
      else if (sel_out)  rd_mux = out_q;
      else if (sel_own)  rd_mux = DATA_W'(owner_q);
      else if (sel_stat) rd_mux = stat_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (h_rd) rdata_q <= rd_mux;
   end

   assign h_rdata = rdata_q;

   // interrupts
   assign f_irq = cmd_q[CMD_MASTER_BIT] && cmd_q[CMD_FW_EN_BIT];
   assign h_irq = cmd_q[CMD_STAT_EN_BIT] &&
                  (stat_q[ST_HANG_BIT] || stat_q[ST_EVENT_BIT]);

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              h_wr,
   input logic              f_claim,
   input logic              f_post,
   input logic              f_hang,
   input logic              f_take,
   input logic [1:0]        f_owner,
   input logic              h_irq,
   input logic              f_irq,
   input logic [DATA_W-1:0] out_word,
   input logic [DATA_W-1:0] stat_word
);

   // R2: the owner code never takes the unused value
   always @(posedge clk) begin
      if (rst_n) begin
         assert_owner_code_R2: assert (f_owner != 2'd3)
            else $error("owner register holds an illegal code");
      end
   end

   // R2: firmware cannot disturb host ownership
   assert_host_own_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (f_owner == 2'd2 && !h_wr) |=> (f_owner == 2'd2));

   // R3: firmware claim on a free mailbox without host traffic succeeds
   assert_fw_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (f_owner == 2'd0 && f_claim && !h_wr) |=> (f_owner == 2'd1));

   // R4: no direct hand-over from firmware to host
   assert_no_direct_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (f_owner == 2'd1) |=> (f_owner != 2'd2));

   // R6: a post without firmware ownership leaves the outbound word alone
   assert_post_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (f_post && f_owner != 2'd1) |=> $stable(out_word));

   // R7: firmware interrupt holds until a take or a host write
   assert_fw_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (f_irq && !f_take && !h_wr) |=> f_irq);

   // R8: a hang strobe always lands in the status flag
   assert_hang_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      f_hang |=> stat_word[1]);

   // R9: host interrupt stays up until the host writes something
   assert_host_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (h_irq && !h_wr) |=> h_irq);

endmodule

bind hostfw_mailbox mbox_checker #(
   .DATA_W (32)
) u_mbox_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .h_wr      (h_wr),
   .f_claim   (f_claim),
   .f_post    (f_post),
   .f_hang    (f_hang),
   .f_take    (f_take),
   .f_owner   (f_owner),
   .h_irq     (h_irq),
   .f_irq     (f_irq),
   .out_word  (out_q),
   .stat_word (stat_q)
);

// File: tb/tb_hostfw_mailbox.sv
module tb_hostfw_mailbox;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_wr = 1'b0;
   logic        h_rd = 1'b0;
   logic [11:0] h_addr = '0;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_rdata;
   logic        h_irq;
   logic        f_claim = 1'b0;
   logic        f_release = 1'b0;
   logic        f_take = 1'b0;
   logic        f_hang = 1'b0;
   logic        f_post = 1'b0;
   logic [7:0]  f_out_type = '0;
   logic [23:0] f_out_data = '0;
   logic        f_irq;
   logic [1:0]  f_owner;
   logic [7:0]  f_in_type;
   logic [23:0] f_in_data;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   hostfw_mailbox dut (
      .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
      .f_claim(f_claim), .f_release(f_release), .f_take(f_take),
      .f_hang(f_hang), .f_post(f_post), .f_out_type(f_out_type),
      .f_out_data(f_out_data), .f_irq(f_irq), .f_owner(f_owner),
      .f_in_type(f_in_type), .f_in_data(f_in_data)
   );

   // ---------------- behavioural reference model ----------------
   logic [1:0]  m_own;
   logic [31:0] m_cmd, m_in, m_out, m_stat, m_rd;

   function automatic logic [31:0] mread(input logic [11:0] a);
      case (a)
         12'hE4:  return m_cmd;
         12'hE8:  return m_in;
         12'hEC:  return m_out;
         12'hF0:  return {30'd0, m_own};
         12'h428: return m_stat;
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_own <= 2'd0; m_cmd <= '0; m_in <= '0; m_out <= '0;
         m_stat <= '0; m_rd <= '0;
      end else begin : model_step
         logic [1:0]  n_own;
         logic [31:0] clr, setv;
         logic        owned, pst;
         owned = (m_own != 2'd0);
         pst   = f_post && (m_own == 2'd1);
         if (h_rd) m_rd <= mread(h_addr);
         n_own = m_own;
         if (f_claim && m_own == 2'd0) n_own = 2'd1;
         else if (h_wr && h_addr == 12'hF0 && h_wdata == 32'd2 && m_own == 2'd0) n_own = 2'd2;
         else if (h_wr && h_addr == 12'hF0 && h_wdata == 32'd0) n_own = 2'd0;
         else if (f_release && m_own == 2'd1) n_own = 2'd0;
         m_own <= n_own;
         if (h_wr && h_addr == 12'hE8 && owned) m_in <= h_wdata;
         if (pst) m_out <= {f_out_type, f_out_data};
         if (h_wr && h_addr == 12'hE4 && owned) m_cmd <= h_wdata & 32'hF800_0000;
         else if (f_take) m_cmd <= m_cmd & ~32'h0800_0000;
         clr  = (h_wr && h_addr == 12'h428) ? (h_wdata & 32'h0000_000A) : 32'd0;
         setv = {28'd0, pst && m_cmd[29], 1'b0, f_hang, 1'b0};
         m_stat <= (m_stat & ~clr) | setv;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every output on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10 model h_rdata", h_rdata, m_rd);
         chk("R2 model f_owner", {30'd0, f_owner}, {30'd0, m_own});
         chk("R7 model f_irq", {31'd0, f_irq}, {31'd0, m_cmd[31] & m_cmd[27]});
         chk("R9 model h_irq", {31'd0, h_irq},
             {31'd0, m_cmd[29] & (m_stat[1] | m_stat[3])});
         chk("R5 model inbound", {f_in_type, f_in_data}, m_in);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(negedge clk);
      h_wr = 1'b0; h_rd = 1'b0; f_claim = 1'b0; f_release = 1'b0;
      f_take = 1'b0; f_hang = 1'b0; f_post = 1'b0;
   endtask

   task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
      h_wr = 1'b1; h_addr = a; h_wdata = d;
      step();
   endtask

   task automatic hread_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      h_rd = 1'b1; h_addr = a;
      step();
      chk(tag, h_rdata, exp);
   endtask

   task automatic fpost(input logic [7:0] t, input logic [23:0] d);
      f_post = 1'b1; f_out_type = t; f_out_data = d;
      step();
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired checks=%0d", checks);
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 h_irq low", {31'd0, h_irq}, 32'd0);
      chk("R1 f_irq low", {31'd0, f_irq}, 32'd0);
      hread_chk("R1 owner free", 12'hF0, 32'd0);
      hread_chk("R1 command zero", 12'hE4, 32'd0);
      hread_chk("R1 status zero", 12'h428, 32'd0);
      hread_chk("R1 outbound zero", 12'hEC, 32'd0);
      hread_chk("R1 inbound zero", 12'hE8, 32'd0);

      // R2 illegal code ignored, R5 write while free ignored
      hwrite(12'hF0, 32'd1);
      hread_chk("R2 code 1 from host ignored", 12'hF0, 32'd0);
      hwrite(12'hE8, 32'hDEAD_BEEF);
      hread_chk("R5 inbound write while free ignored", 12'hE8, 32'd0);
      hwrite(12'hE4, 32'hF800_0000);
      hread_chk("R7 command write while free ignored", 12'hE4, 32'd0);

      // R3 same-cycle claim: firmware wins
      h_wr = 1'b1; h_addr = 12'hF0; h_wdata = 32'd2; f_claim = 1'b1;
      step();
      chk("R3 tie goes to firmware", {30'd0, f_owner}, 32'd1);
      hread_chk("R3 owner readback", 12'hF0, 32'd1);
      hwrite(12'hF0, 32'd2);
      hread_chk("R2 host claim on owned mailbox ignored", 12'hF0, 32'd1);

      // R6 post without status enable
      fpost(8'h05, 24'h123456);
      hread_chk("R6 outbound packing", 12'hEC, 32'h0512_3456);
      hread_chk("R8 no event while disabled", 12'h428, 32'd0);
      chk("R9 no host irq while disabled", {31'd0, h_irq}, 32'd0);

      // R9 post with status enable
      hwrite(12'hE4, 32'h2000_0000);
      fpost(8'h03, 24'hABCDEF);
      hread_chk("R6 second outbound word", 12'hEC, 32'h03AB_CDEF);
      hread_chk("R8 event flag set", 12'h428, 32'h0000_0008);
      chk("R9 host irq raised", {31'd0, h_irq}, 32'd1);
      step(); step();
      chk("R9 host irq held", {31'd0, h_irq}, 32'd1);

      // R5 ACK reply, R7 delivery
      hwrite(12'hE8, 32'h8000_0042);
      chk("R5 ACK type", {24'd0, f_in_type}, 32'h80);
      chk("R5 ACK payload", {8'd0, f_in_data}, 32'h42);
      hwrite(12'hE4, 32'hFFFF_FFFF);
      hread_chk("R7 unimplemented bits read 0", 12'hE4, 32'hF800_0000);
      chk("R7 firmware irq raised", {31'd0, f_irq}, 32'd1);
      hwrite(12'hE4, 32'hA800_0000);
      f_take = 1'b1;
      step();
      chk("R7 take drops firmware irq", {31'd0, f_irq}, 32'd0);
      hread_chk("R7 take clears bit 27 only", 12'hE4, 32'hA000_0000);

      // R8 set wins over same-cycle clear
      h_wr = 1'b1; h_addr = 12'h428; h_wdata = 32'h8;
      f_post = 1'b1; f_out_type = 8'h01; f_out_data = 24'h000001;
      step();
      hread_chk("R8 set wins same-cycle clear", 12'h428, 32'h0000_0008);
      hwrite(12'h428, 32'h8);
      hread_chk("R8 write one clears", 12'h428, 32'd0);
      chk("R9 host irq drops on clear", {31'd0, h_irq}, 32'd0);
      f_hang = 1'b1;
      step();
      hread_chk("R8 hang flag", 12'h428, 32'h0000_0002);
      chk("R9 host irq from hang", {31'd0, h_irq}, 32'd1);
      hwrite(12'hE4, 32'h8000_0000);
      chk("R9 host irq drops with bit 29", {31'd0, h_irq}, 32'd0);
      hread_chk("R8 flag kept after enable cleared", 12'h428, 32'h0000_0002);
      hwrite(12'h428, 32'hFFFF_FFFF);
      hread_chk("R8 all flags cleared", 12'h428, 32'd0);

      // R4 release, R6 post while free
      hwrite(12'hF0, 32'd0);
      chk("R4 host release", {30'd0, f_owner}, 32'd0);
      fpost(8'h09, 24'h999999);
      hread_chk("R6 post while free ignored", 12'hEC, 32'h0100_0001);
      f_release = 1'b1;
      step();
      chk("R4 release while free no effect", {30'd0, f_owner}, 32'd0);
      hwrite(12'hE4, 32'hF800_0000);
      hread_chk("R7 command kept while free", 12'hE4, 32'h8000_0000);

      // host ownership
      hwrite(12'hF0, 32'd2);
      chk("R2 host claim on free", {30'd0, f_owner}, 32'd2);
      f_claim = 1'b1;
      step();
      chk("R3 firmware claim on host-owned ignored", {30'd0, f_owner}, 32'd2);
      f_release = 1'b1;
      step();
      chk("R4 firmware release on host-owned ignored", {30'd0, f_owner}, 32'd2);
      hwrite(12'hE8, 32'h8100_0007);
      chk("R5 NAK type", {24'd0, f_in_type}, 32'h81);
      chk("R5 NAK payload", {8'd0, f_in_data}, 32'h7);
      fpost(8'h0F, 24'h00000F);
      hread_chk("R6 post while host-owned ignored", 12'hEC, 32'h0100_0001);
      hwrite(12'hF0, 32'd0);
      chk("R4 host release of own claim", {30'd0, f_owner}, 32'd0);

      // firmware claim and release, R10 read hold
      f_claim = 1'b1;
      step();
      hread_chk("R3 firmware claim on free", 12'hF0, 32'd1);
      step();
      chk("R10 read data holds", h_rdata, 32'd1);
      f_release = 1'b1;
      step();
      chk("R4 firmware release", {30'd0, f_owner}, 32'd0);
      chk("R10 read data holds across change", h_rdata, 32'd1);
      hread_chk("R10 fresh read", 12'hF0, 32'd0);
      hread_chk("R10 unmapped offset reads 0", 12'h100, 32'd0);

      step();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule